// File: doc/BRIEF.md
# DDR3 Clock-Enable Power-State Monitor

This block watches the command pins and the clock-enable line of a DDR3-style memory device and follows the device's power state. It tracks when banks open, reads, writes, precharges, refreshes, power-down in both its active and its precharge form, and self-refresh. On every rising clock edge it looks at three things: the clock-enable level registered on the previous edge, the level on this edge, and the command decoded from the active-low chip select, row strobe, column strobe and write enable. From these it picks the next state. The monitor also receives the number of banks that are still open, so it can choose between the two power-down flavours and decide where a finished operation lands.

A controller under test or a bus checker uses the block to catch protocol misuse. Any illegal command at a clock-enable transition raises a one-cycle error pulse with a code that names the violation. The same applies to an early clock-enable change, a premature clock-enable drop after a mode-register write, and a non-idle command or early read after self-refresh exit. Every timing window is a parameter counted in clock cycles.

Named states and their transitions: IDLE goes to ACTIVE on ACTIVATE and to REFRESHING on REFRESH. ACTIVE goes to READING, WRITING or PRECHARGING on READ, WRITE or PRECHARGE. READING, WRITING and PRECHARGING restart on a new READ, WRITE or PRECHARGE. After a fixed latency they complete to IDLE when no bank is open and to ACTIVE otherwise. REFRESHING completes to IDLE. A clock-enable fall with an idle command takes a state to ACT_PD or PRE_PD. A clock-enable fall with REFRESH from IDLE takes it to SELF_REF. A clock-enable rise returns ACT_PD to ACTIVE, PRE_PD to IDLE and SELF_REF to IDLE.

Top module: `cke_pwr_monitor`

## Requirements
- R1: After reset the state output is IDLE, no error is pulsed, the clock-enable is taken as high, and the hold and mode-register windows count as already satisfied. State codes: IDLE=0, ACTIVE=1, READING=2, WRITING=3, PRECHARGING=4, REFRESHING=5, ACT_PD=6, PRE_PD=7, SELF_REF=8.
- R2: With clock-enable high on both edges, commands drive the state as follows. With chip select high the command is DESELECT. With chip select low, {ras_n,cas_n,we_n} = 111 is NOP, 011 ACTIVATE, 101 READ, 100 WRITE, 010 PRECHARGE, 001 REFRESH and 000 mode-register write. READING, WRITING and PRECHARGING complete on the OP_LAT-th edge after their command, to IDLE when open_banks is 0 and to ACTIVE otherwise. REFRESHING completes to IDLE on the REF_LAT-th edge.
- R3: On an edge where clock-enable falls, any command other than NOP or DESELECT pulses error code 1. On an edge where it rises, such a command pulses code 2.
- R4: A fall with REFRESH enters SELF_REF only from IDLE. From any other state the same edge pulses code 3.
- R5: A fall with NOP or DESELECT moves IDLE and REFRESHING to PRE_PD and ACTIVE to ACT_PD. From READING, WRITING or PRECHARGING it goes to PRE_PD when open_banks is 0 and to ACT_PD otherwise. A rise with NOP or DESELECT returns ACT_PD to ACTIVE, PRE_PD to IDLE and SELF_REF to IDLE.
- R6: While clock-enable is low on both edges, the command pins are ignored: the state holds and no error is raised.
- R7: A clock-enable change on an edge before the old level has been registered on TCKEMIN consecutive edges pulses code 4.
- R8: On each of the TXS edges after a self-refresh exit, any command other than NOP or DESELECT pulses code 5.
- R9: A READ on any of the TXSDLL edges after a self-refresh exit pulses code 6, unless code 5 applies.
- R10: A clock-enable fall fewer than max(TMRD,TMOD) edges after a mode-register write pulses code 7.
- R11: Errors appear on err_valid/err_code for one cycle after the offending edge. On a flagged edge the state does not change. When several violations coincide, only one code is reported, in this priority order: 4, then 7, then 1/2/3, then 5, then 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock-enable level at this edge |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| open_banks | input | BANK_W | Number of banks currently open |
| state_o | output | 4 | Tracked power state code |
| err_valid | output | 1 | One-cycle error pulse |
| err_code | output | 3 | Violation code, valid with err_valid |

## Verification
A wrong internal state shows up at state_o in the cycle after the edge that caused it. It also bends every later transition, so a bad power-down flavour appears as the wrong return state when clock-enable next rises. Counting faults in the hold, exit or mode-register windows show up only at a window boundary: an error pulse appears one edge too early or too late, or a legal command is flagged. The bench therefore drives commands exactly on the last busy edge and the first free edge of every window, and compares state and error code after every single edge.

// File: rtl/cke_mon_pkg.sv
package cke_mon_pkg;

    typedef enum logic [3:0] {
        ST_IDLE     = 4'd0,
        ST_ACTIVE   = 4'd1,
        ST_READ     = 4'd2,
        ST_WRITE    = 4'd3,
        ST_PRECHG   = 4'd4,
        ST_REFRESH  = 4'd5,
        ST_ACT_PD   = 4'd6,
        ST_PRE_PD   = 4'd7,
        ST_SELF_REF = 4'd8
    } pstate_e;

    typedef enum logic [2:0] {
        ERR_NONE  = 3'd0,
        ERR_ENTRY = 3'd1,
        ERR_EXIT  = 3'd2,
        ERR_SREF  = 3'd3,
        ERR_HOLD  = 3'd4,
        ERR_XS    = 3'd5,
        ERR_XSDLL = 3'd6,
        ERR_MODE  = 3'd7
    } perr_e;

    typedef enum logic [3:0] {
        C_DES   = 4'd0,
        C_NOP   = 4'd1,
        C_ACT   = 4'd2,
        C_RD    = 4'd3,
        C_WR    = 4'd4,
        C_PRE   = 4'd5,
        C_REF   = 4'd6,
        C_MRS   = 4'd7,
        C_OTHER = 4'd8
    } pcmd_e;

endpackage

// File: rtl/cke_cmd_decode.sv
module cke_cmd_decode
    import cke_mon_pkg::*;
(
    input  logic  cs_n,
    input  logic  ras_n,
    input  logic  cas_n,
    input  logic  we_n,
    output pcmd_e cmd,
    output logic  quiet
);

    always_comb begin
        if (cs_n) begin
            cmd = C_DES;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b111:  cmd = C_NOP;
                3'b011:  cmd = C_ACT;
                3'b101:  cmd = C_RD;
                3'b100:  cmd = C_WR;
                3'b010:  cmd = C_PRE;
                3'b001:  cmd = C_REF;
                3'b000:  cmd = C_MRS;
                default: cmd = C_OTHER;
            endcase
        end
    end

    assign quiet = (cmd == C_DES) || (cmd == C_NOP);

endmodule

// File: rtl/cke_hold_guard.sv
module cke_hold_guard #(
    parameter int TCKEMIN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cke,
    output logic cke_q,
    output logic hold_viol
);

    localparam int RW = $clog2(TCKEMIN + 1);
    localparam logic [RW-1:0] RUN_SAT = RW'(TCKEMIN);

    logic [RW-1:0] run_q;
    logic          change;

    assign change    = (cke != cke_q);
    assign hold_viol = change && (run_q < RUN_SAT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cke_q <= 1'b1;
            run_q <= RUN_SAT;
        end else begin
            cke_q <= cke;
            if (change)
                run_q <= RW'(1);
            else if (run_q < RUN_SAT)
                run_q <= run_q + RW'(1);
        end
    end

    // a freshly changed level has been seen on exactly one edge
    AST_RUN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (cke != cke_q) |=> (run_q == RW'(1)));   // R7

endmodule

// File: rtl/cke_exit_timers.sv
module cke_exit_timers #(
    parameter int TXS      = 5,
    parameter int TXSDLL   = 512,
    parameter int MOD_WAIT = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sr_exit,
    input  logic mrs_seen,
    output logic xs_busy,
    output logic dll_busy,
    output logic mode_busy
);

    localparam int XW = $clog2(TXS + 1);
    localparam int DW = $clog2(TXSDLL + 1);
    localparam int MW = $clog2(MOD_WAIT + 1);
    localparam logic [MW-1:0] AGE_SAT = MW'(MOD_WAIT);

    logic [XW-1:0] xs_cnt;
    logic [DW-1:0] dll_cnt;
    logic [MW-1:0] mode_age;

    assign xs_busy   = (xs_cnt != '0);
    assign dll_busy  = (dll_cnt != '0);
    assign mode_busy = (mode_age < AGE_SAT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xs_cnt   <= '0;
            dll_cnt  <= '0;
            mode_age <= AGE_SAT;
        end else begin
            if (sr_exit)
                xs_cnt <= XW'(TXS);
            else if (xs_busy)
                xs_cnt <= xs_cnt - XW'(1);

            if (sr_exit)
                dll_cnt <= DW'(TXSDLL);
            else if (dll_busy)
                dll_cnt <= dll_cnt - DW'(1);

            if (mrs_seen)
                mode_age <= MW'(1);
            else if (mode_busy)
                mode_age <= mode_age + MW'(1);
        end
    end

    generate
        if (TXSDLL >= TXS) begin : g_nest
            AST_DLL_COVERS_XS: assert property (@(posedge clk) disable iff (!rst_n)
                xs_busy |-> dll_busy);   // R9
        end
    endgenerate

endmodule

// File: rtl/cke_state_fsm.sv
module cke_state_fsm
    import cke_mon_pkg::*;
#(
    parameter int OP_LAT  = 4,
    parameter int REF_LAT = 8,
    parameter int BANK_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke,
    input  logic              cke_q,
    input  pcmd_e             cmd,
    input  logic              quiet,
    input  logic [BANK_W-1:0] open_banks,
    input  logic              hold_viol,
    input  logic              mode_busy,
    input  logic              xs_busy,
    input  logic              dll_busy,
    output pstate_e           state,
    output logic              err_valid,
    output perr_e             err_code,
    output logic              sr_exit
);

    localparam int MAXLAT = (OP_LAT > REF_LAT) ? OP_LAT : REF_LAT;
    localparam int OPW    = $clog2(MAXLAT + 1);

    pstate_e        nxt;
    perr_e          code;
    logic [OPW-1:0] op_cnt, op_nxt;
    logic           fall, rise, banks_shut;

    assign fall       = cke_q && !cke;
    assign rise       = !cke_q && cke;
    assign banks_shut = (open_banks == '0);

    always_comb begin
        nxt     = state;
        code    = ERR_NONE;
        op_nxt  = op_cnt;
        sr_exit = 1'b0;
        if (fall) begin
            if (hold_viol)
                code = ERR_HOLD;
            else if (mode_busy)
                code = ERR_MODE;
            else if (cmd == C_REF) begin
                if (state == ST_IDLE) nxt = ST_SELF_REF;
                else                  code = ERR_SREF;
            end else if (!quiet)
                code = ERR_ENTRY;
            else begin
                unique case (state)
                    ST_IDLE, ST_REFRESH:          nxt = ST_PRE_PD;
                    ST_ACTIVE:                    nxt = ST_ACT_PD;
                    ST_READ, ST_WRITE, ST_PRECHG: nxt = banks_shut ? ST_PRE_PD : ST_ACT_PD;
                    default:                      nxt = state;
                endcase
            end
        end else if (rise) begin
            if (hold_viol)
                code = ERR_HOLD;
            else if (!quiet)
                code = ERR_EXIT;
            else begin
                unique case (state)
                    ST_ACT_PD:   nxt = ST_ACTIVE;
                    ST_PRE_PD:   nxt = ST_IDLE;
                    ST_SELF_REF: begin
                        nxt     = ST_IDLE;
                        sr_exit = 1'b1;
                    end
                    default:     nxt = state;
                endcase
            end
        end else if (cke) begin
            if (xs_busy && !quiet)
                code = ERR_XS;
            else if (dll_busy && (cmd == C_RD))
                code = ERR_XSDLL;
            else begin
                unique case (state)
                    ST_IDLE: begin
                        if (cmd == C_ACT) nxt = ST_ACTIVE;
                        else if (cmd == C_REF) begin
                            nxt    = ST_REFRESH;
                            op_nxt = OPW'(REF_LAT);
                        end
                    end
                    ST_ACTIVE, ST_READ, ST_WRITE, ST_PRECHG: begin
                        if (cmd == C_RD) begin
                            nxt    = ST_READ;
                            op_nxt = OPW'(OP_LAT);
                        end else if (cmd == C_WR) begin
                            nxt    = ST_WRITE;
                            op_nxt = OPW'(OP_LAT);
                        end else if (cmd == C_PRE) begin
                            nxt    = ST_PRECHG;
                            op_nxt = OPW'(OP_LAT);
                        end else if (state != ST_ACTIVE) begin
                            if (op_cnt <= OPW'(1))
                                nxt = banks_shut ? ST_IDLE : ST_ACTIVE;
                            else
                                op_nxt = op_cnt - OPW'(1);
                        end
                    end
                    ST_REFRESH: begin
                        if (op_cnt <= OPW'(1)) nxt = ST_IDLE;
                        else                   op_nxt = op_cnt - OPW'(1);
                    end
                    default: nxt = state;
                endcase
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            op_cnt <= '0;
        end else begin
            state  <= nxt;
            op_cnt <= op_nxt;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_valid <= 1'b0;
            err_code  <= ERR_NONE;
        end else begin
            err_valid <= (code != ERR_NONE);
            err_code  <= code;
        end
    end

    AST_LOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_q && !cke) |=> $stable(state));   // R6
    AST_ERR_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> (state == $past(state)));   // R11
    AST_SR_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_SELF_REF) && ($past(state) != ST_SELF_REF)) |-> ($past(state) == ST_IDLE));   // R4

endmodule

// File: rtl/cke_pwr_monitor.sv
module cke_pwr_monitor
    import cke_mon_pkg::*;
#(
    parameter int TCKEMIN = 3,
    parameter int TXS     = 5,
    parameter int TXSDLL  = 512,
    parameter int TMRD    = 4,
    parameter int TMOD    = 12,
    parameter int OP_LAT  = 4,
    parameter int REF_LAT = 8,
    parameter int BANK_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BANK_W-1:0] open_banks,
    output logic [3:0]        state_o,
    output logic              err_valid,
    output logic [2:0]        err_code
);

    localparam int MOD_WAIT = (TMRD > TMOD) ? TMRD : TMOD;

    pcmd_e   cmd;
    logic    quiet, cke_q, hold_viol;
    logic    xs_busy, dll_busy, mode_busy, sr_exit, mrs_seen;
    pstate_e state;
    perr_e   code;

    assign mrs_seen = (cmd == C_MRS) && cke && cke_q;

    cke_cmd_decode u_dec (
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .cmd(cmd), .quiet(quiet)
    );

    cke_hold_guard #(.TCKEMIN(TCKEMIN)) u_hold (
        .clk(clk), .rst_n(rst_n), .cke(cke),
        .cke_q(cke_q), .hold_viol(hold_viol)
    );

    cke_exit_timers #(.TXS(TXS), .TXSDLL(TXSDLL), .MOD_WAIT(MOD_WAIT)) u_tmr (
        .clk(clk), .rst_n(rst_n), .sr_exit(sr_exit), .mrs_seen(mrs_seen),
        .xs_busy(xs_busy), .dll_busy(dll_busy), .mode_busy(mode_busy)
    );

    cke_state_fsm #(.OP_LAT(OP_LAT), .REF_LAT(REF_LAT), .BANK_W(BANK_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cke_q(cke_q), .cmd(cmd),
        .quiet(quiet), .open_banks(open_banks), .hold_viol(hold_viol),
        .mode_busy(mode_busy), .xs_busy(xs_busy), .dll_busy(dll_busy),
        .state(state), .err_valid(err_valid), .err_code(code), .sr_exit(sr_exit)
    );

    assign state_o  = state;
    assign err_code = code;

    AST_RISE_NEEDS_IDLE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_q && cke && !quiet) |=> err_valid);   // R3

endmodule

// File: tb/cke_pwr_monitor_test.sv
module cke_pwr_monitor_test;

    localparam int PERIOD = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cke = 1'b1;
    logic       cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [3:0] open_banks = '0;
    logic [3:0] state_o;
    logic       err_valid;
    logic [2:0] err_code;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [3:0] q_state[$];
    logic [2:0] q_code[$];
    string      q_tag[$];

    localparam int K_DES = 0, K_NOP = 1, K_ACT = 2, K_RD = 3, K_WR = 4,
                   K_PRE = 5, K_REF = 6, K_MRS = 7;

    cke_pwr_monitor #(
        .TCKEMIN(3), .TXS(5), .TXSDLL(10), .TMRD(4), .TMOD(6),
        .OP_LAT(3), .REF_LAT(4), .BANK_W(4)
    ) uut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .open_banks(open_banks),
        .state_o(state_o), .err_valid(err_valid), .err_code(err_code)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // driver: apply one edge of stimulus and queue the expected result
    task automatic step(input logic c, input int k, input logic [3:0] banks,
                        input logic [3:0] exp_st, input logic [2:0] exp_cd,
                        input string tag);
        @(negedge clk);
        cke = c;
        open_banks = banks;
        cs_n = 1'b0;
        case (k)
            K_DES: begin cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b111; end
            K_NOP: {ras_n, cas_n, we_n} = 3'b111;
            K_ACT: {ras_n, cas_n, we_n} = 3'b011;
            K_RD:  {ras_n, cas_n, we_n} = 3'b101;
            K_WR:  {ras_n, cas_n, we_n} = 3'b100;
            K_PRE: {ras_n, cas_n, we_n} = 3'b010;
            K_REF: {ras_n, cas_n, we_n} = 3'b001;
            default: {ras_n, cas_n, we_n} = 3'b000;
        endcase
        q_state.push_back(exp_st);
        q_code.push_back(exp_cd);
        q_tag.push_back(tag);
    endtask

    // monitor: compare after each edge
    always @(posedge clk) begin
        #2;
        if (q_state.size() != 0) begin
            logic [3:0] es;
            logic [2:0] ec;
            string      tg;
            es = q_state.pop_front();
            ec = q_code.pop_front();
            tg = q_tag.pop_front();
            checks++;
            if (state_o !== es || err_valid !== (ec != 3'd0) || err_code !== ec) begin
                errors++;
                $display("FAIL %s: state=%0d err=%0b code=%0d expected state=%0d err=%0b code=%0d",
                         tg, state_o, err_valid, err_code, es, (ec != 3'd0), ec);
            end
        end
    end

    initial begin
        #(PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        checks++;
        if (state_o !== 4'd0 || err_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: state=%0d err=%0b expected state=0 err=0", state_o, err_valid);
        end
        step(1, K_NOP, 0, 0, 0, "R1 idle after reset");
        step(1, K_ACT, 1, 1, 0, "R2 activate");
        step(1, K_RD,  1, 2, 0, "R2 read");
        step(1, K_NOP, 1, 2, 0, "R2 read busy");
        step(1, K_NOP, 1, 2, 0, "R2 read busy");
        step(1, K_NOP, 1, 1, 0, "R2 read done banks open");
        step(1, K_WR,  1, 3, 0, "R2 write");
        step(1, K_PRE, 0, 4, 0, "R2 precharge restarts");
        step(1, K_NOP, 0, 4, 0, "R2 precharge busy");
        step(1, K_NOP, 0, 4, 0, "R2 precharge busy");
        step(1, K_NOP, 0, 0, 0, "R2 precharge done banks shut");
        step(1, K_REF, 0, 5, 0, "R2 refresh");
        for (int i = 0; i < 3; i++) step(1, K_NOP, 0, 5, 0, "R2 refresh busy");
        step(1, K_NOP, 0, 0, 0, "R2 refresh done");
        step(0, K_NOP, 0, 7, 0, "R5 idle to precharge power-down");
        step(0, K_ACT, 0, 7, 0, "R6 ignored while low");
        step(0, K_WR,  0, 7, 0, "R6 ignored while low");
        step(1, K_DES, 0, 0, 0, "R5 exit to idle");
        step(0, K_NOP, 0, 0, 4, "R7 early fall");
        step(0, K_NOP, 0, 0, 0, "R6 low hold");
        step(0, K_NOP, 0, 0, 0, "R6 low hold");
        step(1, K_NOP, 0, 0, 0, "R7 rise after full hold");
        step(1, K_NOP, 0, 0, 0, "R1 idle");
        step(1, K_NOP, 0, 0, 0, "R1 idle");
        step(1, K_MRS, 0, 0, 0, "R10 mode write");
        step(0, K_NOP, 0, 0, 7, "R10 fall too soon");
        step(0, K_NOP, 0, 0, 0, "R6 low");
        step(0, K_NOP, 0, 0, 0, "R6 low");
        step(1, K_NOP, 0, 0, 0, "R10 rise");
        step(1, K_NOP, 0, 0, 0, "R10 wait");
        step(1, K_NOP, 0, 0, 0, "R10 wait");
        step(0, K_REF, 0, 8, 0, "R4 self-refresh entry");
        step(0, K_ACT, 0, 8, 0, "R6 ignored in self-refresh");
        step(0, K_NOP, 0, 8, 0, "R6 self-refresh hold");
        step(1, K_RD,  0, 8, 2, "R3 bad exit command");
        step(1, K_NOP, 0, 8, 0, "R11 state held");
        step(1, K_NOP, 0, 8, 0, "R11 state held");
        step(0, K_NOP, 0, 8, 0, "R6 back low");
        step(0, K_NOP, 0, 8, 0, "R6 low");
        step(0, K_NOP, 0, 8, 0, "R6 low");
        step(1, K_NOP, 0, 0, 0, "R5 self-refresh exit");
        step(1, K_ACT, 0, 0, 5, "R8 command in exit window");
        for (int i = 0; i < 4; i++) step(1, K_NOP, 0, 0, 0, "R8 idle commands");
        step(1, K_ACT, 1, 1, 0, "R8 window over");
        step(1, K_RD,  1, 1, 6, "R9 read too early");
        for (int i = 0; i < 3; i++) step(1, K_NOP, 1, 1, 0, "R9 wait");
        step(1, K_RD,  1, 2, 0, "R9 read allowed");
        step(0, K_NOP, 2, 6, 0, "R5 read to active power-down");
        step(0, K_NOP, 2, 6, 0, "R6 low");
        step(0, K_NOP, 2, 6, 0, "R6 low");
        step(1, K_NOP, 2, 1, 0, "R5 exit to active");
        step(1, K_NOP, 2, 1, 0, "R2 active hold");
        step(1, K_NOP, 2, 1, 0, "R2 active hold");
        step(0, K_WR,  2, 1, 1, "R3 bad entry command");
        step(0, K_NOP, 2, 1, 0, "R6 low");
        step(0, K_NOP, 2, 1, 0, "R6 low");
        step(1, K_NOP, 2, 1, 0, "R11 rise in active");
        step(1, K_NOP, 2, 1, 0, "R2 active hold");
        step(1, K_NOP, 2, 1, 0, "R2 active hold");
        step(0, K_REF, 2, 1, 3, "R4 self-refresh from active");
        step(0, K_NOP, 2, 1, 0, "R11 single-cycle pulse");
        repeat (3) @(posedge clk);
        #5;
        done = 1'b1;
        finish_run();
    end

endmodule